// File: doc/BRIEF.md
# Segment Address Translator with Protection Checks

This block turns a segmented logical address, a segment number plus an offset into that segment, into a physical address. Each segment is described by a base (the physical start address) and a limit (the segment length in addressable units). The descriptors live in a small bank of internal slots, loaded through a write port. A context register pair selects which run of slots forms the active process's table: a table base gives the first slot, and a table length gives how many segments that process may use. On a context switch, software reloads this pair to point at the new process's table.

Each request is checked twice before any address is formed. The segment number is first compared against the table length; a number at or above it names an undefined segment. Only if that passes is the offset compared against the selected segment's limit. A failure on either check raises a trap with a code that tells the two apart, and no address is produced. When both checks pass, the physical address is the segment base plus the offset. The result is registered and appears with a valid strobe one cycle after the request.

Top module: `seg_xlate`

## Requirements
- R1: While reset is held, and until the first request after it, vld_o and trap_o are 0; reset clears the table length to 0 and the table base to 0, so the first request after reset traps with code 1.
- R2: A request with req_i high at a rising edge gives vld_o high right after that edge, with the result for that request; vld_o is low after any edge where req_i is low.
- R3: A segment number greater than or equal to the table length traps with trap_code_o = 1 (undefined segment). This check has priority: the selected slot's limit is not considered.
- R4: A valid segment number whose offset is greater than or equal to that segment's limit traps with trap_code_o = 2 (offset overflow).
- R5: When both checks pass, trap_o is 0, trap_code_o is 0 and paddr_o equals segment base plus offset modulo 2^PA_W (for example base 4300, limit 400, offset 53 gives 4353).
- R6: On any trap, trap_o is 1 and paddr_o is 0.
- R7: Segment number s uses slot (table base + s) modulo the slot count; asserting ctx_ld_i loads both the table base and the table length together.
- R8: A table write or a context load in the same cycle as a request takes effect from the next edge; that request is judged with the values held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write one descriptor slot |
| wr_idx_i | input | SLOT_W | Absolute slot index to write |
| wr_base_i | input | PA_W | Segment base to store |
| wr_lim_i | input | OFF_W+1 | Segment limit to store |
| ctx_ld_i | input | 1 | Load table base and table length |
| ctx_base_i | input | SLOT_W | First slot of the active table |
| ctx_len_i | input | SEG_W+1 | Number of valid segments |
| req_i | input | 1 | Translation request |
| seg_i | input | SEG_W | Segment number |
| off_i | input | OFF_W | Offset within the segment |
| vld_o | output | 1 | Result valid |
| trap_o | output | 1 | Protection violation |
| trap_code_o | output | 2 | 0 none, 1 undefined segment, 2 offset overflow |
| paddr_o | output | PA_W | Physical address, 0 on trap |

## Verification
A translation request can coincide with a descriptor write to the very slot it reads, or with a context load that changes the table length and base it depends on. The bench drives each pair in one cycle, expecting the request to be judged on the old descriptor or old context, then repeats the request alone and expects the new values. Priority of the segment check is provoked by pointing an out-of-range segment at a slot whose zero limit would also fail, and the trap code must still read 1.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    TRAP_NONE = 2'd0,
    TRAP_SEG  = 2'd1,
    TRAP_OFF  = 2'd2
  } trap_e;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SLOT_W = 4,
  parameter int BASE_W = 16,
  parameter int LIM_W  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_idx_i,
  input  logic [BASE_W-1:0] wr_base_i,
  input  logic [LIM_W-1:0]  wr_lim_i,
  input  logic [SLOT_W-1:0] rd_idx_i,
  output logic [BASE_W-1:0] rd_base_o,
  output logic [LIM_W-1:0]  rd_lim_o
);
  localparam int SLOTS = 1 << SLOT_W;

  logic [BASE_W-1:0] base_q [SLOTS];
  logic [LIM_W-1:0]  lim_q  [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g] <= '0;
        lim_q[g]  <= '0;
      end else if (wr_en_i && wr_idx_i == SLOT_W'(g)) begin
        base_q[g] <= wr_base_i;
        lim_q[g]  <= wr_lim_i;
      end
    end
  end

  assign rd_base_o = base_q[rd_idx_i];
  assign rd_lim_o  = lim_q[rd_idx_i];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic [SEG_W:0]   len_i,
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [OFF_W:0]   lim_i,
  output trap_e            code_o,
  output logic [PA_W-1:0]  paddr_o
);
  logic seg_bad, off_bad;

  assign seg_bad = {1'b0, seg_i} >= len_i;
  assign off_bad = {1'b0, off_i} >= lim_i;

  // segment check first; limit only matters for a defined segment
  always_comb begin
    code_o  = TRAP_NONE;
    paddr_o = '0;
    if (seg_bad)      code_o = TRAP_SEG;
    else if (off_bad) code_o = TRAP_OFF;
    else              paddr_o = base_i + PA_W'(off_i);
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 3,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 16,
  parameter int SLOT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_idx_i,
  input  logic [PA_W-1:0]   wr_base_i,
  input  logic [OFF_W:0]    wr_lim_i,
  input  logic              ctx_ld_i,
  input  logic [SLOT_W-1:0] ctx_base_i,
  input  logic [SEG_W:0]    ctx_len_i,
  input  logic              req_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic              vld_o,
  output logic              trap_o,
  output logic [1:0]        trap_code_o,
  output logic [PA_W-1:0]   paddr_o
);
  localparam int LEN_W = SEG_W + 1;
  localparam int LIM_W = OFF_W + 1;

  logic [SLOT_W-1:0] tbl_base_q;
  logic [LEN_W-1:0]  tbl_len_q;
  logic [SLOT_W-1:0] rd_idx;
  logic [PA_W-1:0]   rd_base;
  logic [LIM_W-1:0]  rd_lim;
  trap_e             code_d, code_q;
  logic [PA_W-1:0]   paddr_d, paddr_q;
  logic              vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_base_q <= '0;
      tbl_len_q  <= '0;
    end else if (ctx_ld_i) begin
      tbl_base_q <= ctx_base_i;
      tbl_len_q  <= ctx_len_i;
    end
  end

  // slot index wraps around the bank
  assign rd_idx = tbl_base_q + SLOT_W'(seg_i);

  seg_table #(.SLOT_W(SLOT_W), .BASE_W(PA_W), .LIM_W(LIM_W)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_base_i(wr_base_i),
    .wr_lim_i (wr_lim_i),
    .rd_idx_i (rd_idx),
    .rd_base_o(rd_base),
    .rd_lim_o (rd_lim)
  );

  seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_check (
    .len_i  (tbl_len_q),
    .seg_i  (seg_i),
    .off_i  (off_i),
    .base_i (rd_base),
    .lim_i  (rd_lim),
    .code_o (code_d),
    .paddr_o(paddr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      code_q  <= TRAP_NONE;
      paddr_q <= '0;
    end else begin
      vld_q <= req_i;
      if (req_i) begin
        code_q  <= code_d;
        paddr_q <= paddr_d;
      end
    end
  end

  assign vld_o       = vld_q;
  assign trap_o      = vld_q && (code_q != TRAP_NONE);
  assign trap_code_o = code_q;
  assign paddr_o     = paddr_q;

  a_r2_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o);
  a_r2_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !vld_o);
  a_r3_seg_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ({1'b0, seg_i} >= tbl_len_q)) |=> (trap_code_o == TRAP_SEG) && trap_o);
  a_r4_off_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ({1'b0, seg_i} < tbl_len_q) && ({1'b0, off_i} >= rd_lim))
      |=> (trap_code_o == TRAP_OFF) && trap_o);
  a_r5_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ({1'b0, seg_i} < tbl_len_q) && ({1'b0, off_i} < rd_lim))
      |=> !trap_o && paddr_o == $past(rd_base + PA_W'(off_i)));
  a_r6_trap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && trap_o) |-> paddr_o == '0);
endmodule

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic [15:0] wr_base_i = '0;
  logic [12:0] wr_lim_i = '0;
  logic        ctx_ld_i = 1'b0;
  logic [3:0]  ctx_base_i = '0;
  logic [3:0]  ctx_len_i = '0;
  logic        req_i = 1'b0;
  logic [2:0]  seg_i = '0;
  logic [11:0] off_i = '0;
  logic        vld_o, trap_o;
  logic [1:0]  trap_code_o;
  logic [15:0] paddr_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int m_base [16];
  int m_lim  [16];
  int m_cb = 0;
  int m_cl = 0;

  always #4 clk_i = ~clk_i;

  seg_xlate u0 (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(int seg, int off, output int code, output int pa);
    int slot;
    slot = (m_cb + seg) % 16;
    pa = 0;
    if (seg >= m_cl)           code = 1;
    else if (off >= m_lim[slot]) code = 2;
    else begin code = 0; pa = (m_base[slot] + off) & 16'hFFFF; end
  endfunction

  task automatic check_out(string tag, int code, int pa);
    chk({tag, " vld"}, vld_o, 1);
    chk({tag, " code"}, trap_code_o, code);
    chk({tag, " trap"}, trap_o, code != 0);
    chk({tag, " paddr"}, paddr_o, pa);
  endtask

  task automatic tbl_write(int idx, int base, int lim);
    @(negedge clk_i);
    wr_en_i = 1; wr_idx_i = 4'(idx); wr_base_i = 16'(base); wr_lim_i = 13'(lim);
    @(negedge clk_i);
    wr_en_i = 0;
    m_base[idx] = base; m_lim[idx] = lim;
  endtask

  task automatic ctx_load(int b, int l);
    @(negedge clk_i);
    ctx_ld_i = 1; ctx_base_i = 4'(b); ctx_len_i = 4'(l);
    @(negedge clk_i);
    ctx_ld_i = 0;
    m_cb = b; m_cl = l;
  endtask

  task automatic xlate(string tag, int seg, int off);
    int code, pa;
    model(seg, off, code, pa);
    @(negedge clk_i);
    req_i = 1; seg_i = 3'(seg); off_i = 12'(off);
    @(negedge clk_i);
    req_i = 0;
    check_out(tag, code, pa);
  endtask

  task automatic t_reset;
    chk("R1 vld in reset", vld_o, 0);
    chk("R1 trap in reset", trap_o, 0);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);
    chk("R1 vld after reset", vld_o, 0);
    xlate("R1 first req traps seg", 0, 0);
  endtask

  task automatic t_basic;
    tbl_write(2, 4300, 400);
    tbl_write(0, 100, 16);
    ctx_load(0, 5);
    xlate("R5 base 4300 off 53", 2, 53);
    chk("R5 literal 4353", paddr_o, 4353);
    xlate("R5 last in range", 2, 399);
    xlate("R5 slot0", 0, 15);
    @(negedge clk_i);
    chk("R2 idle vld low", vld_o, 0);
  endtask

  task automatic t_limit;
    xlate("R4 off equal limit", 2, 400);
    xlate("R6 off far beyond", 2, 4095);
    xlate("R4 zero limit slot", 1, 0);
  endtask

  task automatic t_priority;
    tbl_write(5, 200, 0);
    xlate("R3 seg equal length", 5, 9);
    xlate("R3 seg top", 7, 4095);
  endtask

  task automatic t_wrap;
    tbl_write(1, 16'hFFF0, 100);
    tbl_write(14, 50, 10);
    ctx_load(14, 4);
    xlate("R7 wrap seg3 to slot1", 3, 32);
    chk("R5 modulo sum", paddr_o, 16);
    xlate("R7 seg0 to slot14", 0, 3);
    xlate("R3 after ctx load", 4, 0);
  endtask

  task automatic t_same_cycle;
    int code, pa;
    model(0, 5, code, pa);
    @(negedge clk_i);
    req_i = 1; seg_i = 3'd0; off_i = 12'd5;
    wr_en_i = 1; wr_idx_i = 4'd14; wr_base_i = 16'd7000; wr_lim_i = 13'd2;
    @(negedge clk_i);
    req_i = 0; wr_en_i = 0;
    check_out("R8 write same cycle uses old", code, pa);
    m_base[14] = 7000; m_lim[14] = 2;
    xlate("R8 write seen next", 0, 5);
    xlate("R8 new base", 0, 1);
    model(3, 32, code, pa);
    @(negedge clk_i);
    req_i = 1; seg_i = 3'd3; off_i = 12'd32;
    ctx_ld_i = 1; ctx_base_i = 4'd0; ctx_len_i = 4'd2;
    @(negedge clk_i);
    req_i = 0; ctx_ld_i = 0;
    check_out("R8 ctx same cycle uses old", code, pa);
    m_cb = 0; m_cl = 2;
    xlate("R8 ctx seen next", 3, 32);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_base[i] = 0; m_lim[i] = 0; end
    repeat (3) @(negedge clk_i);
    t_reset;
    t_basic;
    t_limit;
    t_priority;
    t_wrap;
    t_same_cycle;
    repeat (2) @(negedge clk_i);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule